// File: doc/BRIEF.md
# Bus-Sharing Video Timing Controller

This block sits beside a Z80-style CPU and a discrete video fetch engine and decides, frame by frame, who owns the memory bus. It holds the machine's general-purpose output register and its video page register, and it serves the general-purpose input port. The CPU reaches all three through an I/O address, an 8-bit write data bus and a single-cycle write strobe.

Each frame is `FRAME_CLKS` clocks long. When the screen is on, the first `DISP_CLKS` clocks of the frame form the display window. During that window the block raises a bus request. Once the CPU answers with bus acknowledge, the block issues one video fetch per clock. The fetch address joins the page register, as the upper address bits, to a character counter, as the lower bits. At the end of the window the request drops and the CPU resumes. With the screen bit cleared, the block never requests the bus, so the CPU runs without pause.

A change to the screen bit is sampled only at a frame boundary, so a display window that has started always runs to its end. All registers clear on reset. The relay and LED outputs are active low, so both start active, and the screen starts off.

Top module: `vid_bus_share`

## Requirements
- R1: After reset, `cas_out`, `relay_n`, `led_n`, `user_out` and `busreq` are all 0, and the page register is 0.
- R2: A write to I/O address 0xF0 loads the output register from the write data: bit 0 drives `cas_out`, bit 1 drives `relay_n` (0 = relay on), bit 2 is the screen enable, bits 3 and 4 drive `user_out[0]` and `user_out[1]`, bit 5 drives `led_n` (0 = LED on), and bits 6 and 7 are dropped. Outputs change on the clock edge that samples the write.
- R3: A write to 0xF1 loads write data bits 7:1 into the page register, which appears on `vf_addr[15:9]` (bit 1 on A9 and upward). Write data bit 0 has no effect on `vf_addr`.
- R4: Whenever `io_addr` is 0xF2, `io_rdata` combinationally returns `{dip_sw[3:0], 1'b0, user_in[1:0], cas_in}`, with bit 3 always 0. For any other address it returns 0.
- R5: With the screen active, `busreq` is 1 during frame phases 0 to `DISP_CLKS-1` and 0 for the rest of the frame. Frame phase 0 is the first clock after reset release, and phases repeat every `FRAME_CLKS` clocks.
- R6: `vf_en` is 1 only while `busreq` and `busack` are both 1. With the default parameters the grant is combinational, so `vf_en` follows `busack` in the same cycle.
- R7: While the screen enable bit is 0 at a frame boundary, `busreq` stays 0 for the whole of the following frame.
- R8: The screen enable bit is sampled only at the boundary into phase 0. A change made during a display window leaves that window at its full length, and the change applies from the next frame.
- R9: `vf_addr[8:0]` is 0 at phase 0 and advances by 1 on every clock edge at which `vf_en` is 1. At phase k it therefore equals the number of granted cycles since phase 0.
- R10: Writes to any address other than 0xF0 and 0xF1, including the input port 0xF2, change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (input port) |
| cas_in | input | 1 | Cassette input level |
| user_in | input | 2 | User input bits |
| dip_sw | input | 4 | Board switch levels A to D |
| cas_out | output | 1 | Cassette output level |
| relay_n | output | 1 | Cassette relay control, 0 = on |
| led_n | output | 1 | Cassette LED, 0 = lit |
| user_out | output | 2 | User output bits |
| busreq | output | 1 | Bus request to the CPU |
| busack | input | 1 | Bus acknowledge from the CPU |
| vf_en | output | 1 | Video fetch active this cycle |
| vf_addr | output | CHAR_W+PAGE_W | Video fetch address |

## Verification
Register outputs are due on the edge that samples the write, so the bench drives a write at a falling edge and checks it at the next falling edge. The input port and the fetch grant are combinational, so they are checked 1 ns after their inputs change, in the same cycle. The bench counts rising edges since reset release to track the frame phase. It samples `busreq` and the character bits at chosen phases, where R5 and R9 give the value: for example, with acknowledge raised at phase 4, the expected value at phase 10 is 6.

// File: rtl/vbs_pkg.sv
package vbs_pkg;
   localparam logic [7:0] PORT_GPO  = 8'hF0;
   localparam logic [7:0] PORT_PAGE = 8'hF1;
   localparam logic [7:0] PORT_GPI  = 8'hF2;

   // field order matches the output port bit positions 5..0
   typedef struct packed {
      logic       led_n;
      logic [1:0] user;
      logic       scr_en;
      logic       relay_n;
      logic       cas;
   } gpo_t;
endpackage

// File: rtl/vbs_ports.sv
module vbs_ports
   import vbs_pkg::*;
#(
   parameter int PAGE_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_wr,
   input  logic [7:0]        io_addr,
   input  logic [7:0]        io_wdata,
   output logic [7:0]        io_rdata,
   input  logic              cas_in,
   input  logic [1:0]        user_in,
   input  logic [3:0]        dip_sw,
   output gpo_t              gpo,
   output logic [PAGE_W-1:0] page
);
   generate
      if (PAGE_W < 1 || PAGE_W > 7) begin : g_bad_page
         $error("vbs_ports: PAGE_W must be 1..7");
      end
   endgenerate

   logic wr_gpo, wr_page;
   assign wr_gpo  = io_wr && (io_addr == PORT_GPO);
   assign wr_page = io_wr && (io_addr == PORT_PAGE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gpo  <= '0;
         page <= '0;
      end else begin
         if (wr_gpo)  gpo  <= gpo_t'(io_wdata[5:0]);
         if (wr_page) page <= io_wdata[PAGE_W:1];
      end
   end

   always_comb begin
      io_rdata = '0;
      if (io_addr == PORT_GPI)
         io_rdata = {dip_sw, 1'b0, user_in, cas_in};
   end
endmodule

// File: rtl/vbs_frame_timer.sv
module vbs_frame_timer #(
   parameter int FRAME_CLKS = 64,
   parameter int DISP_CLKS  = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scr_en,
   output logic frame_wrap,
   output logic busreq
);
   localparam int FCNT_W = (FRAME_CLKS > 2) ? $clog2(FRAME_CLKS) : 1;
   localparam logic [FCNT_W-1:0] LAST = FCNT_W'(FRAME_CLKS - 1);
   localparam logic [FCNT_W-1:0] DISP = FCNT_W'(DISP_CLKS);

   generate
      if (DISP_CLKS < 1 || DISP_CLKS >= FRAME_CLKS) begin : g_bad_win
         $error("vbs_frame_timer: need 1 <= DISP_CLKS < FRAME_CLKS");
      end
   endgenerate

   logic [FCNT_W-1:0] fcnt;
   logic              scr_act;

   assign frame_wrap = (fcnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fcnt    <= '0;
         scr_act <= 1'b0;
      end else if (frame_wrap) begin
         fcnt    <= '0;
         scr_act <= scr_en;
      end else begin
         fcnt    <= fcnt + 1'b1;
      end
   end

   assign busreq = scr_act && (fcnt < DISP);
endmodule

// File: rtl/vbs_fetch.sv
module vbs_fetch #(
   parameter int CHAR_W   = 9,
   parameter int PAGE_W   = 7,
   parameter bit ACK_SYNC = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     busreq,
   input  logic                     busack,
   input  logic                     frame_wrap,
   input  logic [PAGE_W-1:0]        page,
   output logic                     vf_en,
   output logic [CHAR_W+PAGE_W-1:0] vf_addr
);
   generate
      if (CHAR_W < 1) begin : g_bad_char
         $error("vbs_fetch: CHAR_W must be positive");
      end
   endgenerate

   logic grant;

   generate
      if (ACK_SYNC) begin : g_ack_reg
         logic ack_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ack_q <= 1'b0;
            else        ack_q <= busack && busreq;
         end
         assign grant = busreq && ack_q;
      end else begin : g_ack_comb
         assign grant = busreq && busack;
      end
   endgenerate

   logic [CHAR_W-1:0] char_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          char_cnt <= '0;
      else if (frame_wrap) char_cnt <= '0;
      else if (grant)      char_cnt <= char_cnt + 1'b1;
   end

   assign vf_en   = grant;
   assign vf_addr = {page, char_cnt};
endmodule

// File: rtl/vid_bus_share.sv
module vid_bus_share
   import vbs_pkg::*;
#(
   parameter int FRAME_CLKS = 64,
   parameter int DISP_CLKS  = 32,
   parameter int CHAR_W     = 9,
   parameter int PAGE_W     = 7,
   parameter bit ACK_SYNC   = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     io_wr,
   input  logic [7:0]               io_addr,
   input  logic [7:0]               io_wdata,
   output logic [7:0]               io_rdata,
   input  logic                     cas_in,
   input  logic [1:0]               user_in,
   input  logic [3:0]               dip_sw,
   output logic                     cas_out,
   output logic                     relay_n,
   output logic                     led_n,
   output logic [1:0]               user_out,
   output logic                     busreq,
   input  logic                     busack,
   output logic                     vf_en,
   output logic [CHAR_W+PAGE_W-1:0] vf_addr
);
   gpo_t              gpo;
   logic [PAGE_W-1:0] page;
   logic              frame_wrap;
   logic              scr_en;

   vbs_ports #(.PAGE_W(PAGE_W)) u_ports (
      .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .cas_in(cas_in),
      .user_in(user_in), .dip_sw(dip_sw), .gpo(gpo), .page(page)
   );

   assign scr_en   = gpo.scr_en;
   assign cas_out  = gpo.cas;
   assign relay_n  = gpo.relay_n;
   assign led_n    = gpo.led_n;
   assign user_out = gpo.user;

   vbs_frame_timer #(.FRAME_CLKS(FRAME_CLKS), .DISP_CLKS(DISP_CLKS)) u_timer (
      .clk(clk), .rst_n(rst_n), .scr_en(scr_en),
      .frame_wrap(frame_wrap), .busreq(busreq)
   );

   vbs_fetch #(.CHAR_W(CHAR_W), .PAGE_W(PAGE_W), .ACK_SYNC(ACK_SYNC)) u_fetch (
      .clk(clk), .rst_n(rst_n), .busreq(busreq), .busack(busack),
      .frame_wrap(frame_wrap), .page(page), .vf_en(vf_en), .vf_addr(vf_addr)
   );
endmodule

// File: rtl/vbs_checker.sv
module vbs_checker #(
   parameter int FRAME_CLKS = 64,
   parameter int DISP_CLKS  = 32,
   parameter int CHAR_W     = 9,
   parameter int PAGE_W     = 7
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     busreq,
   input logic                     busack,
   input logic                     vf_en,
   input logic [CHAR_W+PAGE_W-1:0] vf_addr,
   input logic                     frame_wrap,
   input logic                     scr_en
);
   localparam int PH_W = $clog2(FRAME_CLKS) + 1;

   logic [PH_W-1:0] phase;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          phase <= '0;
      else if (frame_wrap) phase <= '0;
      else                 phase <= phase + 1'b1;
   end

   AST_REQ_OPENS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busreq) |-> (phase == '0)); // R5

   AST_REQ_FULL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busreq) |-> (phase == PH_W'(DISP_CLKS))); // R8

   AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busreq) |-> $past(scr_en)); // R7

   AST_FETCH_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
      vf_en |-> (busreq && (busack || $past(busack)))); // R6

   AST_CHAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      vf_en |=> (vf_addr[CHAR_W-1:0] == CHAR_W'($past(vf_addr[CHAR_W-1:0]) + 1'b1))); // R9
endmodule

bind vid_bus_share vbs_checker #(
   .FRAME_CLKS(FRAME_CLKS), .DISP_CLKS(DISP_CLKS), .CHAR_W(CHAR_W), .PAGE_W(PAGE_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .busreq(busreq), .busack(busack), .vf_en(vf_en),
   .vf_addr(vf_addr), .frame_wrap(frame_wrap), .scr_en(scr_en)
);

// File: tb/tb_vid_bus_share.sv
module tb_vid_bus_share;
   localparam int FRAME = 64;
   localparam int DISP  = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        io_wr = 1'b0;
   logic [7:0]  io_addr = 8'h00;
   logic [7:0]  io_wdata = 8'h00;
   logic [7:0]  io_rdata;
   logic        cas_in = 1'b0;
   logic [1:0]  user_in = 2'b00;
   logic [3:0]  dip_sw = 4'h0;
   logic        cas_out, relay_n, led_n, busreq, vf_en;
   logic [1:0]  user_out;
   logic        busack = 1'b0;
   logic [15:0] vf_addr;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   vid_bus_share #(.FRAME_CLKS(FRAME), .DISP_CLKS(DISP)) dut (
      .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .cas_in(cas_in),
      .user_in(user_in), .dip_sw(dip_sw), .cas_out(cas_out),
      .relay_n(relay_n), .led_n(led_n), .user_out(user_out),
      .busreq(busreq), .busack(busack), .vf_en(vf_en), .vf_addr(vf_addr)
   );

   always #5 clk = ~clk;

   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic io_write(input logic [7:0] a, input logic [7:0] d);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0; io_addr = 8'h00;
   endtask

   task automatic wait_phase(input int ph);
      do @(negedge clk); while ((cyc % FRAME) != ph);
   endtask

   task automatic outs(output logic [4:0] v);
      v = {led_n, user_out, relay_n, cas_out};
   endtask

   task automatic t_reset;
      logic [4:0] v;
      outs(v);
      chk("R1 outputs", v, 5'b0);
      chk("R1 busreq", busreq, 1'b0);
      chk("R1 page", vf_addr[15:9], 7'h00);
   endtask

   task automatic t_screen_off;
      int seen = 0;
      for (int i = 0; i < FRAME; i++) begin
         @(negedge clk);
         if (busreq) seen++;
      end
      chk("R7 no request while off", seen, 0);
   endtask

   task automatic t_outport;
      logic [4:0] v;
      io_write(8'hF0, 8'h3B);
      outs(v);
      chk("R2 write 0x3B", v, 5'b11111);
      io_write(8'hF0, 8'hC2);
      outs(v);
      chk("R2 write 0xC2", v, 5'b00010);
   endtask

   task automatic t_inport;
      io_addr = 8'hF2; cas_in = 1'b1; user_in = 2'b10; dip_sw = 4'hA;
      #1 chk("R4 read pattern 1", io_rdata, 8'hA5);
      cas_in = 1'b0; user_in = 2'b01; dip_sw = 4'h5;
      #1 chk("R4 read pattern 2", io_rdata, 8'h52);
      io_addr = 8'hF0;
      #1 chk("R4 other address", io_rdata, 8'h00);
      io_addr = 8'h00;
   endtask

   task automatic t_other_addr;
      logic [4:0] v;
      io_write(8'hF2, 8'hFF);
      io_write(8'hF3, 8'hFF);
      io_write(8'h70, 8'hFF);
      outs(v);
      chk("R10 stray writes", v, 5'b00010);
      chk("R10 page untouched", vf_addr[15:9], 7'h00);
   endtask

   task automatic t_display;
      io_write(8'hF1, 8'hA5);
      io_write(8'hF0, 8'h04);
      busack = 1'b0;
      wait_phase(0);
      chk("R5 request at phase 0", busreq, 1'b1);
      chk("R6 no fetch before ack", vf_en, 1'b0);
      busack = 1'b1;
      #1 chk("R6 fetch after ack", vf_en, 1'b1);
      chk("R9 char at phase 0", vf_addr[8:0], 9'd0);
      chk("R3 page bits", vf_addr[15:9], 7'h52);
      wait_phase(5);
      chk("R9 char at phase 5", vf_addr[8:0], 9'd5);
      io_write(8'hF1, 8'hA4);
      chk("R3 bit 0 ignored", vf_addr[15:9], 7'h52);
      wait_phase(DISP - 1);
      chk("R5 request at last display phase", busreq, 1'b1);
      wait_phase(DISP);
      chk("R5 request dropped after window", busreq, 1'b0);
      chk("R6 fetch stops", vf_en, 1'b0);
      busack = 1'b0;
   endtask

   task automatic t_ack_delay;
      wait_phase(4);
      busack = 1'b1;
      wait_phase(10);
      chk("R9 delayed ack count", vf_addr[8:0], 9'd6);
      busack = 1'b0;
      #1 chk("R6 fetch follows ack", vf_en, 1'b0);
   endtask

   task automatic t_boundary;
      wait_phase(3);
      io_write(8'hF0, 8'h00);
      wait_phase(10);
      chk("R8 window continues after disable", busreq, 1'b1);
      wait_phase(DISP - 1);
      chk("R8 window full length", busreq, 1'b1);
      wait_phase(0);
      chk("R8 off from next frame", busreq, 1'b0);
      wait_phase(5);
      chk("R7 stays off", busreq, 1'b0);
   endtask

   initial begin
      #(150000 * 10);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_screen_off();
      t_outport();
      t_inport();
      t_other_addr();
      t_display();
      t_ack_delay();
      t_boundary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule